// File: doc/BRIEF.md
# Dual-Circuit Edge Time-Stamp Unit

This block records the moment at which a pin changes level, using the value of an external free-running counter as the time stamp. The pin is first brought into the clock domain by a two-flop synchronizer. Two capture circuits watch the resulting signal. Each circuit has its own edge selection and its own two-word FIFO of time stamps. Instead of watching the pin directly, the circuits can watch a derived signal. That signal comes from an 8-bit edge counter and changes level each time the count of pin rising edges reaches a programmed compare value. This makes it possible to time-stamp every Nth pulse.

Capture can run freely, so every selected edge is stored. It can also run in one-shot mode. In that mode circuit 0 takes a single stamp, then circuit 1 takes a single stamp, and the unit then waits to be re-armed. Each circuit raises a flag when its FIFO holds more words than a programmed watermark. A registered DMA request is derived from one of four sources: off, the enabled watermark flags merged by OR or by AND, a local sync strobe, or a local reload strobe.

Top module: `edge_stamp_unit`

## Requirements
- R1: The pin passes through two synchronizing flops. With the raw pin as source, a captured stamp equals the counter value present at the third rising clock edge after the pin change is first sampled.
- R2: Each circuit has its own 2-bit edge select: 0 captures nothing, 1 captures falling edges, 2 captures rising edges, 3 captures both.
- R3: When the edge-counter source is selected, an 8-bit counter advances on each synchronized pin rising edge. When the incremented value equals the compare value (a compare of 0 acts as 256), the counter clears and the derived signal inverts. The circuits then capture edges of the derived signal, one clock later than for the raw pin. While the raw source is selected, the counter and the derived signal are held at 0.
- R4: With one-shot mode off, every selected edge pushes a stamp into the FIFO of each circuit that selects it.
- R5: In one-shot mode, after reset or an arm pulse, only circuit 0 is armed. Its first capture arms only circuit 1, and circuit 1 does not take that same edge. After circuit 1 captures, no circuit captures until the next arm pulse.
- R6: Each FIFO holds 2 words. A capture into a full FIFO is dropped, unless a read of that FIFO happens in the same cycle; in that case the oldest word leaves and the new word is kept.
- R7: A read pulse loads the oldest word into the read-data output on the next clock and decrements the fill count. A read of an empty FIFO leaves the read data unchanged.
- R8: A circuit's flag is high while its fill count is strictly greater than the watermark.
- R9: The DMA request is registered, one clock after its inputs. Source 0 never requests, 1 uses the merged watermark flags, 2 follows the sync strobe, and 3 follows the reload strobe.
- R10: Under source 1, the flags of the circuits enabled by the 2-bit DMA enable mask (bit c for circuit c) are merged. With the AND control low, any enabled flag requests. With it high, all enabled flags must be set. An empty mask never requests.
- R11: After a synchronous reset, both FIFOs are empty, read data are 0, flags and the DMA request are low, and one-shot arming starts at circuit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous pin being time-stamped |
| timebase_i | input | CNT_W | Free-running counter value used as stamp |
| src_edge_cnt_i | input | 1 | 1 selects the edge-counter derived signal as source |
| edge_cmp_i | input | EC_W | Edge counter compare value |
| edge_sel0_i | input | 2 | Edge select of circuit 0 |
| edge_sel1_i | input | 2 | Edge select of circuit 1 |
| one_shot_i | input | 1 | 1 selects one-shot arming |
| arm_i | input | 1 | Re-arm pulse for one-shot mode |
| rd0_i | input | 1 | Read pulse for FIFO 0 |
| rd1_i | input | 1 | Read pulse for FIFO 1 |
| watermark_i | input | FILL_W | Watermark level for both flags |
| dma_src_i | input | 2 | DMA request source select |
| dma_en_i | input | 2 | Per-circuit flag enable for the DMA merge |
| dma_and_i | input | 1 | 1 merges enabled flags by AND, 0 by OR |
| sync_evt_i | input | 1 | Local sync strobe |
| reload_evt_i | input | 1 | Local reload strobe |
| rd_data0_o | output | CNT_W | Last word read from FIFO 0 |
| rd_data1_o | output | CNT_W | Last word read from FIFO 1 |
| fill0_o | output | FILL_W | Words held in FIFO 0 |
| fill1_o | output | FILL_W | Words held in FIFO 1 |
| flag0_o | output | 1 | Watermark flag of circuit 0 |
| flag1_o | output | 1 | Watermark flag of circuit 1 |
| dma_req_o | output | 1 | Registered DMA request |

## Verification
Two events can fall on the same clock edge, and both are exercised. The first is a new stamp arriving at a full FIFO while that FIFO is being read. The bench fills FIFO 0 and changes the pin. It then raises the read pulse exactly two cycles later, so the read lands on the capture edge. The result is judged by the fill staying at two, the read returning the oldest stamp, and the remaining words coming out in arrival order. The second is the one-shot hand-over, where the edge that fires circuit 0 must not also be stored by circuit 1. Both circuits are set to capture either edge, and the fill counts are checked after each edge.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

    localparam int NUM_CIRC = 2;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef enum logic [1:0] {
        DREQ_OFF    = 2'd0,
        DREQ_WMARK  = 2'd1,
        DREQ_SYNC   = 2'd2,
        DREQ_RELOAD = 2'd3
    } dreq_src_e;

    typedef enum logic [1:0] {
        ARM_FIRST  = 2'd0,
        ARM_SECOND = 2'd1,
        ARM_DONE   = 2'd2
    } arm_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

    function automatic logic edge_hit(input edge_mode_e mode, input edge_evt_t evt);
        case (mode)
            EDGE_FALL: return evt.fall;
            EDGE_RISE: return evt.rise;
            EDGE_BOTH: return evt.rise | evt.fall;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic wm_merge(input logic [NUM_CIRC-1:0] flags,
                                      input logic [NUM_CIRC-1:0] en,
                                      input logic                use_and);
        if (use_and)
            return (en != '0) && ((flags & en) == en);
        return (flags & en) != '0;
    endfunction

endpackage

// File: rtl/esu_edge_front.sv
module esu_edge_front
    import edge_stamp_pkg::*;
#(
    parameter int EC_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pin_i,
    input  logic            use_ec_i,
    input  logic [EC_W-1:0] ec_cmp_i,
    output edge_evt_t       evt_o
);

    logic            sync_a, sync_b, pin_prev;
    logic            ec_sig, src_prev;
    logic [EC_W-1:0] ec_cnt;
    logic [EC_W-1:0] ec_inc;
    logic            pin_rise;
    logic            src;

    assign pin_rise = sync_b & ~pin_prev;
    assign ec_inc   = ec_cnt + 1'b1;
    assign src      = use_ec_i ? ec_sig : sync_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a   <= 1'b0;
            sync_b   <= 1'b0;
            pin_prev <= 1'b0;
            src_prev <= 1'b0;
        end else begin
            sync_a   <= pin_i;
            sync_b   <= sync_a;
            pin_prev <= sync_b;
            src_prev <= src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !use_ec_i) begin
            ec_cnt <= '0;
            ec_sig <= 1'b0;
        end else if (pin_rise) begin
            if (ec_inc == ec_cmp_i) begin
                ec_cnt <= '0;
                ec_sig <= ~ec_sig;
            end else begin
                ec_cnt <= ec_inc;
            end
        end
    end

    assign evt_o.rise = src & ~src_prev;
    assign evt_o.fall = ~src & src_prev;

    // R3: the edge counter only moves on a synchronized rising edge
    a_r3_count_hold: assert property (@(posedge clk) disable iff (rst)
        (use_ec_i && !pin_rise) |=> $stable(ec_cnt));

    // R3: raw source keeps the counter cleared
    a_r3_raw_clear: assert property (@(posedge clk) disable iff (rst)
        !use_ec_i |=> (ec_cnt == '0 && !ec_sig));

endmodule

// File: rtl/esu_capture_fifo.sv
module esu_capture_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             push_i,
    input  logic [DATA_W-1:0]                data_i,
    input  logic                             pop_i,
    output logic [DATA_W-1:0]                rdata_o,
    output logic [$clog2(DEPTH+1)-1:0]       fill_o
);

    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [FILL_W-1:0] count_q;
    logic [DATA_W-1:0] rdata_q;
    logic              full, empty, pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count_q == FILL_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign pop_ok  = pop_i & ~empty;
    assign push_ok = push_i & (~full | pop_ok);

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wptr] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            count_q <= '0;
            rdata_q <= '0;
        end else begin
            if (push_ok)
                wptr <= bump(wptr);
            if (pop_ok) begin
                rdata_q <= mem[rptr];
                rptr    <= bump(rptr);
            end
            count_q <= count_q + FILL_W'(push_ok) - FILL_W'(pop_ok);
        end
    end

    assign rdata_o = rdata_q;
    assign fill_o  = count_q;

    // R6: fill never exceeds the depth
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (rst)
        count_q <= FILL_W'(DEPTH));

    // R6: a capture into a full FIFO without a read is dropped
    a_r6_drop_full: assert property (@(posedge clk) disable iff (rst)
        (full && push_i && !pop_i) |=> ($stable(count_q) && $stable(wptr)));

    // R7: reading an empty FIFO keeps the read data
    a_r7_empty_hold: assert property (@(posedge clk) disable iff (rst)
        (empty && pop_i) |=> $stable(rdata_q));

endmodule

// File: rtl/esu_arm_ctrl.sv
module esu_arm_ctrl
    import edge_stamp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                one_shot_i,
    input  logic                arm_i,
    input  logic [NUM_CIRC-1:0] hit_i,
    output logic [NUM_CIRC-1:0] cap_o
);

    arm_state_e st;

    always_comb begin
        if (!one_shot_i) begin
            cap_o = hit_i;
        end else begin
            case (st)
                ARM_FIRST:  cap_o = {1'b0, hit_i[0]};
                ARM_SECOND: cap_o = {hit_i[1], 1'b0};
                default:    cap_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || arm_i) begin
            st <= ARM_FIRST;
        end else if (one_shot_i) begin
            case (st)
                ARM_FIRST:  if (hit_i[0]) st <= ARM_SECOND;
                ARM_SECOND: if (hit_i[1]) st <= ARM_DONE;
                default:    st <= st;
            endcase
        end
    end

    // R5: once both shots are taken the unit stays idle until re-armed
    a_r5_done_holds: assert property (@(posedge clk) disable iff (rst)
        (one_shot_i && st == ARM_DONE && !arm_i) |=> (st == ARM_DONE));

    // R5: an arm pulse always restarts at circuit 0
    a_r5_rearm: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (st == ARM_FIRST));

endmodule

// File: rtl/esu_dma_req.sv
module esu_dma_req
    import edge_stamp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          src_i,
    input  logic [NUM_CIRC-1:0] flags_i,
    input  logic [NUM_CIRC-1:0] en_i,
    input  logic                and_i,
    input  logic                sync_i,
    input  logic                reload_i,
    output logic                req_o
);

    logic req_d;

    always_comb begin
        case (dreq_src_e'(src_i))
            DREQ_WMARK:  req_d = wm_merge(flags_i, en_i, and_i);
            DREQ_SYNC:   req_d = sync_i;
            DREQ_RELOAD: req_d = reload_i;
            default:     req_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) req_o <= 1'b0;
        else     req_o <= req_d;
    end

    // R9: source 0 never requests
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (src_i == DREQ_OFF) |=> !req_o);

    // R10: an empty enable mask never requests
    a_r10_empty_mask: assert property (@(posedge clk) disable iff (rst)
        (src_i == DREQ_WMARK && en_i == '0) |=> !req_o);

endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
    import edge_stamp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int EC_W   = 8,
    parameter int DEPTH  = 2,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_i,
    input  logic [CNT_W-1:0]  timebase_i,
    input  logic              src_edge_cnt_i,
    input  logic [EC_W-1:0]   edge_cmp_i,
    input  logic [1:0]        edge_sel0_i,
    input  logic [1:0]        edge_sel1_i,
    input  logic              one_shot_i,
    input  logic              arm_i,
    input  logic              rd0_i,
    input  logic              rd1_i,
    input  logic [FILL_W-1:0] watermark_i,
    input  logic [1:0]        dma_src_i,
    input  logic [1:0]        dma_en_i,
    input  logic              dma_and_i,
    input  logic              sync_evt_i,
    input  logic              reload_evt_i,
    output logic [CNT_W-1:0]  rd_data0_o,
    output logic [CNT_W-1:0]  rd_data1_o,
    output logic [FILL_W-1:0] fill0_o,
    output logic [FILL_W-1:0] fill1_o,
    output logic              flag0_o,
    output logic              flag1_o,
    output logic              dma_req_o
);

    edge_evt_t           evt;
    logic [NUM_CIRC-1:0] raw_hit, cap_en, flag_vec;
    logic [1:0]          sel_arr   [NUM_CIRC];
    logic                pop_arr   [NUM_CIRC];
    logic [CNT_W-1:0]    rdata_arr [NUM_CIRC];
    logic [FILL_W-1:0]   fill_arr  [NUM_CIRC];

    assign sel_arr[0] = edge_sel0_i;
    assign sel_arr[1] = edge_sel1_i;
    assign pop_arr[0] = rd0_i;
    assign pop_arr[1] = rd1_i;

    esu_edge_front #(.EC_W(EC_W)) u_front (
        .clk      (clk),
        .rst      (rst),
        .pin_i    (pin_i),
        .use_ec_i (src_edge_cnt_i),
        .ec_cmp_i (edge_cmp_i),
        .evt_o    (evt)
    );

    esu_arm_ctrl u_arm (
        .clk        (clk),
        .rst        (rst),
        .one_shot_i (one_shot_i),
        .arm_i      (arm_i),
        .hit_i      (raw_hit),
        .cap_o      (cap_en)
    );

    for (genvar c = 0; c < NUM_CIRC; c++) begin : g_circ
        assign raw_hit[c] = edge_hit(edge_mode_e'(sel_arr[c]), evt);

        esu_capture_fifo #(.DATA_W(CNT_W), .DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .push_i  (cap_en[c]),
            .data_i  (timebase_i),
            .pop_i   (pop_arr[c]),
            .rdata_o (rdata_arr[c]),
            .fill_o  (fill_arr[c])
        );

        assign flag_vec[c] = fill_arr[c] > watermark_i;
    end

    esu_dma_req u_dma (
        .clk      (clk),
        .rst      (rst),
        .src_i    (dma_src_i),
        .flags_i  (flag_vec),
        .en_i     (dma_en_i),
        .and_i    (dma_and_i),
        .sync_i   (sync_evt_i),
        .reload_i (reload_evt_i),
        .req_o    (dma_req_o)
    );

    assign rd_data0_o = rdata_arr[0];
    assign rd_data1_o = rdata_arr[1];
    assign fill0_o    = fill_arr[0];
    assign fill1_o    = fill_arr[1];
    assign flag0_o    = flag_vec[0];
    assign flag1_o    = flag_vec[1];

    // R5: one-shot never stores the same edge in both circuits
    a_r5_single_store: assert property (@(posedge clk) disable iff (rst)
        one_shot_i |-> !(cap_en[0] && cap_en[1]));

endmodule

// File: tb/edge_stamp_unit_bench.sv
module edge_stamp_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        pin_i, src_edge_cnt_i, one_shot_i, arm_i, rd0_i, rd1_i;
    logic [7:0]  edge_cmp_i;
    logic [1:0]  edge_sel0_i, edge_sel1_i, dma_src_i, dma_en_i;
    logic [1:0]  watermark_i;
    logic        dma_and_i, sync_evt_i, reload_evt_i;
    logic [15:0] rd_data0_o, rd_data1_o;
    logic [1:0]  fill0_o, fill1_o;
    logic        flag0_o, flag1_o, dma_req_o;
    logic [15:0] cyc;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 16'd0;
        else     cyc <= cyc + 16'd1;
    end

    edge_stamp_unit u_edge_stamp_unit (
        .clk(clk), .rst(rst), .pin_i(pin_i), .timebase_i(cyc),
        .src_edge_cnt_i(src_edge_cnt_i), .edge_cmp_i(edge_cmp_i),
        .edge_sel0_i(edge_sel0_i), .edge_sel1_i(edge_sel1_i),
        .one_shot_i(one_shot_i), .arm_i(arm_i), .rd0_i(rd0_i), .rd1_i(rd1_i),
        .watermark_i(watermark_i), .dma_src_i(dma_src_i), .dma_en_i(dma_en_i),
        .dma_and_i(dma_and_i), .sync_evt_i(sync_evt_i), .reload_evt_i(reload_evt_i),
        .rd_data0_o(rd_data0_o), .rd_data1_o(rd_data1_o),
        .fill0_o(fill0_o), .fill1_o(fill1_o), .flag0_o(flag0_o), .flag1_o(flag1_o),
        .dma_req_o(dma_req_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // change the pin at a negedge, note the counter, let the capture settle
    task automatic edge_to(input logic v, output int t);
        @(negedge clk);
        pin_i = v;
        t = int'(cyc);
        step(4);
    endtask

    task automatic pop(input int c, output int d);
        @(negedge clk);
        if (c == 0) rd0_i = 1'b1; else rd1_i = 1'b1;
        @(negedge clk);
        rd0_i = 1'b0;
        rd1_i = 1'b0;
        d = (c == 0) ? int'(rd_data0_o) : int'(rd_data1_o);
    endtask

    task automatic drain();
        int d;
        for (int k = 0; k < 2; k++) begin
            pop(0, d);
            pop(1, d);
        end
    endtask

    task automatic dchk(input string req, input logic [1:0] src, input logic [1:0] en,
                        input logic andm, input logic sy, input logic rl, input int exp);
        @(negedge clk);
        dma_src_i = src; dma_en_i = en; dma_and_i = andm;
        sync_evt_i = sy; reload_evt_i = rl;
        @(negedge clk);
        chk(req, int'(dma_req_o), exp);
    endtask

    function automatic int st(input int t, input int lat);
        return (t + lat) % 65536;
    endfunction

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL R11 watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int t1, t2, t3, d, ta, tb, e0, e1;
        int tr [6];
        rst = 1'b1; pin_i = 1'b0; src_edge_cnt_i = 1'b0; one_shot_i = 1'b0;
        arm_i = 1'b0; rd0_i = 1'b0; rd1_i = 1'b0; edge_cmp_i = 8'd3;
        edge_sel0_i = 2'd0; edge_sel1_i = 2'd0; dma_src_i = 2'd0; dma_en_i = 2'd0;
        watermark_i = 2'd0; dma_and_i = 1'b0; sync_evt_i = 1'b0; reload_evt_i = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);

        // R11 reset state
        chk("R11 fill0", int'(fill0_o), 0);
        chk("R11 fill1", int'(fill1_o), 0);
        chk("R11 rdata0", int'(rd_data0_o), 0);
        chk("R11 rdata1", int'(rd_data1_o), 0);
        chk("R11 flag0", int'(flag0_o), 0);
        chk("R11 flag1", int'(flag1_o), 0);
        chk("R11 dma", int'(dma_req_o), 0);

        // R1 / R4: free-running, circuit 0 rising, circuit 1 falling
        edge_sel0_i = 2'd2; edge_sel1_i = 2'd1;
        edge_to(1'b1, t1);
        edge_to(1'b0, t2);
        chk("R4 fill0 free-run", int'(fill0_o), 1);
        chk("R4 fill1 free-run", int'(fill1_o), 1);
        pop(0, d); chk("R1 rise stamp", d, st(t1, 2));
        pop(1, d); chk("R1 fall stamp", d, st(t2, 2));

        // R2: all edge-select pairs
        for (int s0 = 0; s0 < 4; s0++) begin
            for (int s1 = 0; s1 < 4; s1++) begin
                edge_sel0_i = 2'(s0); edge_sel1_i = 2'(s1);
                edge_to(1'b1, ta);
                edge_to(1'b0, tb);
                e0 = ((s0 & 2) != 0 ? 1 : 0) + ((s0 & 1) != 0 ? 1 : 0);
                e1 = ((s1 & 2) != 0 ? 1 : 0) + ((s1 & 1) != 0 ? 1 : 0);
                chk($sformatf("R2 fill0 sel0=%0d", s0), int'(fill0_o), e0);
                chk($sformatf("R2 fill1 sel1=%0d", s1), int'(fill1_o), e1);
                if (s0 != 0) begin
                    pop(0, d);
                    chk($sformatf("R2 first stamp sel0=%0d", s0), d,
                        ((s0 & 2) != 0) ? st(ta, 2) : st(tb, 2));
                end
                drain();
            end
        end

        // R6 / R7: overflow drop and empty read
        edge_sel0_i = 2'd3; edge_sel1_i = 2'd0;
        edge_to(1'b1, t1);
        edge_to(1'b0, t2);
        edge_to(1'b1, t3);
        chk("R6 fill capped", int'(fill0_o), 2);
        pop(0, d); chk("R6 oldest kept", d, st(t1, 2));
        pop(0, d); chk("R6 second kept", d, st(t2, 2));
        chk("R7 fill after reads", int'(fill0_o), 0);
        pop(0, d); chk("R7 empty read holds", d, st(t2, 2));
        chk("R7 fill stays 0", int'(fill0_o), 0);
        edge_sel0_i = 2'd0;
        edge_to(1'b0, t3);

        // R6: capture lands on a full FIFO in the same cycle as a read
        edge_sel0_i = 2'd3;
        edge_to(1'b1, t1);
        edge_to(1'b0, t2);
        @(negedge clk);
        pin_i = 1'b1;
        t3 = int'(cyc);
        @(negedge clk);
        @(negedge clk);
        rd0_i = 1'b1;
        @(negedge clk);
        rd0_i = 1'b0;
        chk("R6 read on full capture", int'(rd_data0_o), st(t1, 2));
        chk("R6 fill kept at 2", int'(fill0_o), 2);
        pop(0, d); chk("R6 order second", d, st(t2, 2));
        pop(0, d); chk("R6 order new", d, st(t3, 2));
        edge_sel0_i = 2'd0;
        edge_to(1'b0, t3);
        drain();

        // R8 watermark flag
        edge_sel0_i = 2'd2; watermark_i = 2'd0;
        edge_to(1'b1, t1); edge_to(1'b0, t2);
        chk("R8 flag0 fill1 wm0", int'(flag0_o), 1);
        chk("R8 flag1 empty", int'(flag1_o), 0);
        watermark_i = 2'd1;
        step(1);
        chk("R8 flag0 fill1 wm1", int'(flag0_o), 0);
        edge_to(1'b1, t1); edge_to(1'b0, t2);
        chk("R8 flag0 fill2 wm1", int'(flag0_o), 1);

        // R9 / R10 with flag0=1, flag1=0
        dchk("R9 source off", 2'd0, 2'b11, 1'b0, 1'b1, 1'b1, 0);
        dchk("R10 OR both", 2'd1, 2'b11, 1'b0, 1'b0, 1'b0, 1);
        dchk("R10 OR only c1", 2'd1, 2'b10, 1'b0, 1'b0, 1'b0, 0);
        dchk("R10 AND both", 2'd1, 2'b11, 1'b1, 1'b0, 1'b0, 0);
        dchk("R10 AND only c0", 2'd1, 2'b01, 1'b1, 1'b0, 1'b0, 1);
        dchk("R10 AND empty mask", 2'd1, 2'b00, 1'b1, 1'b0, 1'b0, 0);
        dchk("R9 sync high", 2'd2, 2'b00, 1'b0, 1'b1, 1'b0, 1);
        dchk("R9 sync low", 2'd2, 2'b00, 1'b0, 1'b0, 1'b1, 0);
        dchk("R9 reload high", 2'd3, 2'b00, 1'b0, 1'b0, 1'b1, 1);
        dchk("R9 reload low", 2'd3, 2'b00, 1'b0, 1'b1, 1'b0, 0);
        dchk("R9 back off", 2'd0, 2'b00, 1'b0, 1'b0, 1'b0, 0);
        watermark_i = 2'd0;
        drain();

        // R5 one-shot sequence
        one_shot_i = 1'b1; edge_sel0_i = 2'd3; edge_sel1_i = 2'd3;
        @(negedge clk); arm_i = 1'b1;
        @(negedge clk); arm_i = 1'b0;
        edge_to(1'b1, t1);
        chk("R5 first shot c0", int'(fill0_o), 1);
        chk("R5 first shot not c1", int'(fill1_o), 0);
        edge_to(1'b0, t2);
        chk("R5 second shot c0 idle", int'(fill0_o), 1);
        chk("R5 second shot c1", int'(fill1_o), 1);
        edge_to(1'b1, t3);
        chk("R5 done c0", int'(fill0_o), 1);
        chk("R5 done c1", int'(fill1_o), 1);
        @(negedge clk); arm_i = 1'b1;
        @(negedge clk); arm_i = 1'b0;
        edge_to(1'b0, ta);
        chk("R5 rearm c0", int'(fill0_o), 2);
        chk("R5 rearm c1", int'(fill1_o), 1);
        pop(0, d); chk("R5 stamp c0 first", d, st(t1, 2));
        pop(0, d); chk("R5 stamp c0 rearm", d, st(ta, 2));
        pop(1, d); chk("R5 stamp c1", d, st(t2, 2));
        one_shot_i = 1'b0;
        drain();

        // R3 edge counter source, compare 3
        src_edge_cnt_i = 1'b1; edge_cmp_i = 8'd3;
        edge_sel0_i = 2'd2; edge_sel1_i = 2'd1;
        step(2);
        for (int i = 0; i < 6; i++) begin
            edge_to(1'b1, tr[i]);
            edge_to(1'b0, t2);
            if (i == 1) chk("R3 no capture before compare", int'(fill0_o), 0);
        end
        chk("R3 fill0 derived rise", int'(fill0_o), 1);
        chk("R3 fill1 derived fall", int'(fill1_o), 1);
        pop(0, d); chk("R3 stamp third rise", d, st(tr[2], 3));
        pop(1, d); chk("R3 stamp sixth rise", d, st(tr[5], 3));
        src_edge_cnt_i = 1'b0;
        step(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule